// File: doc/BRIEF.md
# Parallel Display Bus Strobe Sequencer

This block generates the chip-select, write-strobe and read-strobe of an asynchronous parallel bus that connects to an LCD controller, together with a register-select line (A0) that marks each transfer as a command or as data. A host offers one transfer at a time on a valid/ready port. A write drives the data bus and pulses CS and WE. A read pulses CS and RE and captures the incoming data bus at a programmed tick.

Every access runs on a tick counter that starts at zero when the request is accepted. Each strobe has a programmable assert tick and release tick. One configuration bit stretches every tick from one input clock to two. The block checks the edge ordering of the timing set before it starts an access. If the set is inconsistent, it rejects the request and raises an error pulse. After the access cycle, a programmable number of recovery ticks keeps the bus idle before the next request is taken. Each strobe and A0 has its own polarity input.

Top module: `pdb_strobe_seq`

## Requirements
- R1: During and right after reset, req_ready is 1, wr_done, rd_valid, cfg_err and bus_oe are 0, every strobe sits at its inactive level, and bus_a0 sits at the command level.
- R2: Let k be the number of clocks since the acceptance edge (k=0 in the clock after that edge) and G be 1, or 2 when cfg_tick_x2 is set. The tick is floor(k/G). A strobe is asserted exactly in the ticks T with on <= T < off.
- R3: For a write (req_read=0), only CS and WE pulse. bus_oe is 1 and bus_dout equals the request data for the whole cycle. wr_done is high for exactly one clock, at k = L*G, where L = max(cfg_wr_cycle, cfg_cs_off).
- R4: For a read (req_read=1), only CS and RE pulse. rd_data takes the bus_din value sampled at the clock edge that starts tick cfg_access. rd_valid is high for exactly one clock, at k = L*G, where L = max(cfg_rd_cycle, cfg_cs_off).
- R5: A request is taken only when req_valid and req_ready are both 1. req_ready stays 0 from the acceptance edge until k = (L + cfg_gap)*G, and is 1 from then on.
- R6: bus_a0 is 0 for a command (req_data_sel=0) and 1 for data, inverted when pol_a0_inv is 1. It is set at acceptance and held for the whole access and until the next one.
- R7: A strobe whose pol_*_hi bit is 1 is asserted high and idles low. With the bit at 0, the strobe is asserted low and idles high.
- R8: A timing set is legal only when all of these hold: WE off > WE on, RE off > RE on, CS off > CS on, CS off >= WE off, CS off >= RE off, write cycle >= WE off, read cycle >= RE off, and RE on < access <= max(read cycle, CS off). A request offered with an illegal set is consumed. cfg_err then pulses for one clock at k=0, no strobe moves, and req_ready stays 1.
- R9: The timing fields and cfg_tick_x2 are sampled at acceptance. Changing them during an access has no effect on that access.
- R10: WE and RE are never asserted in the same clock, and all bus outputs come straight from flip-flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cs_on | input | 4 | CS assert tick |
| cfg_cs_off | input | 6 | CS release tick |
| cfg_we_on | input | 4 | WE assert tick |
| cfg_we_off | input | 6 | WE release tick |
| cfg_re_on | input | 4 | RE assert tick |
| cfg_re_off | input | 6 | RE release tick |
| cfg_wr_cycle | input | 6 | Write cycle length in ticks |
| cfg_rd_cycle | input | 6 | Read cycle length in ticks |
| cfg_gap | input | 6 | Idle recovery ticks after each cycle |
| cfg_access | input | 6 | Read sample tick |
| cfg_tick_x2 | input | 1 | Tick lasts two clocks when 1 |
| pol_cs_hi | input | 1 | CS asserted high when 1 |
| pol_we_hi | input | 1 | WE asserted high when 1 |
| pol_re_hi | input | 1 | RE asserted high when 1 |
| pol_a0_inv | input | 1 | Inverts the A0 level |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block can accept a request |
| req_read | input | 1 | 1 = read access, 0 = write access |
| req_data_sel | input | 1 | 1 = data, 0 = command |
| req_wdata | input | DATA_W | Write data |
| wr_done | output | 1 | One-clock pulse at the end of a write |
| rd_valid | output | 1 | One-clock pulse at the end of a read |
| rd_data | output | DATA_W | Captured read data |
| cfg_err | output | 1 | One-clock pulse on a rejected request |
| bus_cs | output | 1 | Chip select strobe |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| bus_a0 | output | 1 | Command/data select |
| bus_dout | output | DATA_W | Outgoing bus data |
| bus_oe | output | 1 | Output enable for bus_dout |
| bus_din | input | DATA_W | Incoming bus data |

## Verification
Random legal timing sets, in both tick granularities and with random polarities, are checked clock by clock against a tick-window model of the strobes. This separates off-by-one errors on the on and off edges from errors in the cycle length taken as max(cycle, CS off). The incoming data bus changes every clock, so a capture made one clock early or late returns a different word. Directed sets cover the shortest possible cycle back to back with no gap, every field at its maximum with doubled ticks, and a read sampled on its final tick. Illegal orderings each break a single rule. One run rewrites the timing inputs in the middle of an access, which shows whether the fields are held from acceptance.

// File: rtl/pdb_pkg.sv
package pdb_pkg;

    localparam int ON_W  = 4;
    localparam int OFF_W = 6;

    localparam int NLANE   = 3;
    localparam int LANE_CS = 0;
    localparam int LANE_WE = 1;
    localparam int LANE_RE = 2;

    typedef logic [ON_W-1:0]  on_t;
    typedef logic [OFF_W-1:0] tk_t;

    localparam tk_t TK_ONE = tk_t'(1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_GAP  = 2'd2
    } seq_state_e;

    // Timing set, latched as one word when an access starts
    typedef struct packed {
        on_t  cs_on;
        on_t  we_on;
        on_t  re_on;
        tk_t  cs_off;
        tk_t  we_off;
        tk_t  re_off;
        tk_t  wr_cyc;
        tk_t  rd_cyc;
        tk_t  gap;
        tk_t  acc;
        logic x2;
    } timing_t;

    function automatic tk_t widen(on_t v);
        return {{(OFF_W-ON_W){1'b0}}, v};
    endfunction

    function automatic tk_t tk_max(tk_t a, tk_t b);
        return (a > b) ? a : b;
    endfunction

    // Cycle length in ticks: never shorter than the CS window
    function automatic tk_t run_len(timing_t t, logic rd);
        return tk_max(rd ? t.rd_cyc : t.wr_cyc, t.cs_off);
    endfunction

    function automatic logic timing_legal(timing_t t);
        logic ok;
        ok = (t.we_off > widen(t.we_on))
          && (t.re_off > widen(t.re_on))
          && (t.cs_off > widen(t.cs_on))
          && (t.cs_off >= t.we_off)
          && (t.cs_off >= t.re_off)
          && (t.wr_cyc >= t.we_off)
          && (t.rd_cyc >= t.re_off)
          && (t.acc > widen(t.re_on))
          && (t.acc <= run_len(t, 1'b1));
        return ok;
    endfunction

endpackage

// File: rtl/pdb_tick_timer.sv
module pdb_tick_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         en,
    input  logic         x2,
    output logic [W-1:0] tick_q,
    output logic         adv
);
    localparam logic [W-1:0] ONE = W'(1);

    logic half_q;

    // A tick ends on every clock, or on every second clock when doubled
    assign adv = !x2 || half_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            half_q <= 1'b0;
            tick_q <= '0;
        end else if (en) begin
            half_q <= x2 && !half_q;
            if (adv) begin
                tick_q <= tick_q + ONE;
            end
        end
    end

endmodule

// File: rtl/pdb_strobe_lanes.sv
module pdb_strobe_lanes
    import pdb_pkg::*;
#(
    parameter int N = NLANE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run_n,
    input  tk_t                 tick_n,
    input  logic [N-1:0]        lane_en,
    input  logic [N-1:0][ON_W-1:0]  on_v,
    input  logic [N-1:0][OFF_W-1:0] off_v,
    input  logic [N-1:0]        act_hi,
    output logic [N-1:0]        act_q,
    output logic [N-1:0]        pin_q
);
    logic [N-1:0] hit_v;

    for (genvar g = 0; g < N; g++) begin : g_lane
        assign hit_v[g] = run_n && lane_en[g]
                       && (widen(on_v[g]) <= tick_n)
                       && (tick_n < off_v[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            pin_q <= ~act_hi;
        end else begin
            act_q <= hit_v;
            pin_q <= ~(hit_v ^ act_hi);
        end
    end

endmodule

// File: rtl/pdb_read_capture.sv
module pdb_read_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic              fin,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            if (cap) begin
                rd_data <= din;
            end
            rd_valid <= fin;
        end
    end

endmodule

// File: rtl/pdb_strobe_seq.sv
module pdb_strobe_seq
    import pdb_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ON_W-1:0]   cfg_cs_on,
    input  logic [OFF_W-1:0]  cfg_cs_off,
    input  logic [ON_W-1:0]   cfg_we_on,
    input  logic [OFF_W-1:0]  cfg_we_off,
    input  logic [ON_W-1:0]   cfg_re_on,
    input  logic [OFF_W-1:0]  cfg_re_off,
    input  logic [OFF_W-1:0]  cfg_wr_cycle,
    input  logic [OFF_W-1:0]  cfg_rd_cycle,
    input  logic [OFF_W-1:0]  cfg_gap,
    input  logic [OFF_W-1:0]  cfg_access,
    input  logic              cfg_tick_x2,
    input  logic              pol_cs_hi,
    input  logic              pol_we_hi,
    input  logic              pol_re_hi,
    input  logic              pol_a0_inv,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_read,
    input  logic              req_data_sel,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              wr_done,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              cfg_err,
    output logic              bus_cs,
    output logic              bus_we,
    output logic              bus_re,
    output logic              bus_a0,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    input  logic [DATA_W-1:0] bus_din
);
    timing_t    cfg_in, cfg_q, cfg_sel;
    seq_state_e st_q, st_n;

    logic              rd_q, dsel_q;
    logic [DATA_W-1:0] wdata_q;

    tk_t  tick_q, tick_inc, tick_n, len_m1, gap_m1;
    logic adv;
    logic accept, legal_in, start, reject;
    logic last_run, gap_end, run_n, rd_sel, cap;

    logic [NLANE-1:0]            lane_en, act_hi, act_v, pin_v;
    logic [NLANE-1:0][ON_W-1:0]  on_v;
    logic [NLANE-1:0][OFF_W-1:0] off_v;

    assign cfg_in = '{cs_on:  cfg_cs_on,    we_on:  cfg_we_on,    re_on: cfg_re_on,
                      cs_off: cfg_cs_off,   we_off: cfg_we_off,   re_off: cfg_re_off,
                      wr_cyc: cfg_wr_cycle, rd_cyc: cfg_rd_cycle, gap:   cfg_gap,
                      acc:    cfg_access,   x2:     cfg_tick_x2};

    // Handshake and legality
    assign req_ready = (st_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign legal_in  = timing_legal(cfg_in);
    assign start     = accept && legal_in;
    assign reject    = accept && !legal_in;

    // Cycle bookkeeping on the latched set
    assign tick_inc = tick_q + TK_ONE;
    assign len_m1   = run_len(cfg_q, rd_q) - TK_ONE;
    assign gap_m1   = cfg_q.gap - TK_ONE;
    assign last_run = (st_q == ST_RUN) && adv && (tick_q == len_m1);
    assign gap_end  = (st_q == ST_GAP) && adv && (tick_q == gap_m1);

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_IDLE: if (start)    st_n = ST_RUN;
            ST_RUN:  if (last_run) st_n = (cfg_q.gap != '0) ? ST_GAP : ST_IDLE;
            ST_GAP:  if (gap_end)  st_n = ST_IDLE;
            default:               st_n = ST_IDLE;
        endcase
    end

    pdb_tick_timer #(
        .W (OFF_W)
    ) timer_i (
        .clk    (clk),
        .rst    (rst),
        .clear  (start || last_run),
        .en     (st_q != ST_IDLE),
        .x2     (cfg_q.x2),
        .tick_q (tick_q),
        .adv    (adv)
    );

    // Strobes are computed from the tick of the coming clock, so the
    // registered pins line up with the tick count
    assign tick_n  = start ? '0 : (adv ? tick_inc : tick_q);
    assign run_n   = (st_n == ST_RUN);
    assign cfg_sel = start ? cfg_in : cfg_q;
    assign rd_sel  = start ? req_read : rd_q;

    assign on_v[LANE_CS]  = cfg_sel.cs_on;
    assign on_v[LANE_WE]  = cfg_sel.we_on;
    assign on_v[LANE_RE]  = cfg_sel.re_on;
    assign off_v[LANE_CS] = cfg_sel.cs_off;
    assign off_v[LANE_WE] = cfg_sel.we_off;
    assign off_v[LANE_RE] = cfg_sel.re_off;

    assign lane_en[LANE_CS] = 1'b1;
    assign lane_en[LANE_WE] = !rd_sel;
    assign lane_en[LANE_RE] = rd_sel;

    assign act_hi[LANE_CS] = pol_cs_hi;
    assign act_hi[LANE_WE] = pol_we_hi;
    assign act_hi[LANE_RE] = pol_re_hi;

    pdb_strobe_lanes #(
        .N (NLANE)
    ) lanes_i (
        .clk     (clk),
        .rst     (rst),
        .run_n   (run_n),
        .tick_n  (tick_n),
        .lane_en (lane_en),
        .on_v    (on_v),
        .off_v   (off_v),
        .act_hi  (act_hi),
        .act_q   (act_v),
        .pin_q   (pin_v)
    );

    assign bus_cs = pin_v[LANE_CS];
    assign bus_we = pin_v[LANE_WE];
    assign bus_re = pin_v[LANE_RE];

    // Read sample at the edge that opens the access tick
    assign cap = (st_q == ST_RUN) && rd_q && adv && (tick_inc == cfg_q.acc);

    pdb_read_capture #(
        .DATA_W (DATA_W)
    ) rdcap_i (
        .clk      (clk),
        .rst      (rst),
        .cap      (cap),
        .fin      (last_run && rd_q),
        .din      (bus_din),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            cfg_q    <= '0;
            rd_q     <= 1'b0;
            dsel_q   <= 1'b0;
            wdata_q  <= '0;
            bus_a0   <= pol_a0_inv;
            bus_oe   <= 1'b0;
            bus_dout <= '0;
            wr_done  <= 1'b0;
            cfg_err  <= 1'b0;
        end else begin
            st_q <= st_n;
            if (start) begin
                cfg_q   <= cfg_in;
                rd_q    <= req_read;
                dsel_q  <= req_data_sel;
                wdata_q <= req_wdata;
            end
            bus_a0   <= (start ? req_data_sel : dsel_q) ^ pol_a0_inv;
            bus_oe   <= run_n && !rd_sel;
            bus_dout <= start ? req_wdata : wdata_q;
            wr_done  <= last_run && !rd_q;
            cfg_err  <= reject;
        end
    end

    // R10: the two data strobes never overlap
    a_r10_we_re_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(act_v[LANE_WE] && act_v[LANE_RE]));

    // R5: no new request while CS is asserted
    a_r5_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
        act_v[LANE_CS] |-> !req_ready);

    // R3 and R4: end pulses are exclusive
    a_r3_done_excl: assert property (@(posedge clk) disable iff (rst)
        !(wr_done && rd_valid));

    // R8: a rejection leaves the bus idle and the port open
    a_r8_err_idle: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (req_ready && !act_v[LANE_CS]));

    // R6: A0 held through an access
    a_r6_a0_steady: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN && $past(st_q == ST_RUN)) |-> $stable(bus_a0));

    // R2: the tick never passes the end of the cycle
    a_r2_tick_bound: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_RUN) |-> (tick_q <= len_m1));

endmodule

// File: tb/pdb_strobe_seq_tb_top.sv
module pdb_strobe_seq_tb_top;
    localparam int DW = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst;
    logic [3:0] cs_on, we_on, re_on;
    logic [5:0] cs_off, we_off, re_off, wr_cyc, rd_cyc, gap, acc;
    logic x2, pcs, pwe, pre, pa0;
    logic valid, rdreq, dsel;
    logic [DW-1:0] wdata, din;
    logic ready, wr_done, rd_valid, cfg_err, bcs, bwe, bre, ba0, boe;
    logic [DW-1:0] rd_data, bdout;

    int nchk = 0, nfail = 0, cc = 0;
    bit finished = 0;

    pdb_strobe_seq #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst),
        .cfg_cs_on(cs_on), .cfg_cs_off(cs_off), .cfg_we_on(we_on), .cfg_we_off(we_off),
        .cfg_re_on(re_on), .cfg_re_off(re_off), .cfg_wr_cycle(wr_cyc), .cfg_rd_cycle(rd_cyc),
        .cfg_gap(gap), .cfg_access(acc), .cfg_tick_x2(x2),
        .pol_cs_hi(pcs), .pol_we_hi(pwe), .pol_re_hi(pre), .pol_a0_inv(pa0),
        .req_valid(valid), .req_ready(ready), .req_read(rdreq), .req_data_sel(dsel),
        .req_wdata(wdata), .wr_done(wr_done), .rd_valid(rd_valid), .rd_data(rd_data),
        .cfg_err(cfg_err), .bus_cs(bcs), .bus_we(bwe), .bus_re(bre), .bus_a0(ba0),
        .bus_dout(bdout), .bus_oe(boe), .bus_din(din)
    );

    function automatic logic [DW-1:0] hash(int n);
        logic [31:0] v;
        v = 32'(n) * 32'd40503 + 32'd977;
        return v[15:0] ^ v[31:16];
    endfunction

    always @(posedge clk) cc <= cc + 1;
    always @(negedge clk) din <= hash(cc);

    function automatic bit lvl(bit act, logic hi);
        return hi ? act : !act;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic rand_cfg();
        int lr;
        we_on  = 4'($urandom_range(0, 15));
        we_off = 6'(int'(we_on) + $urandom_range(1, 8));
        re_on  = 4'($urandom_range(0, 15));
        re_off = 6'(int'(re_on) + $urandom_range(1, 8));
        cs_on  = 4'($urandom_range(0, 15));
        cs_off = 6'(imax(imax(int'(cs_on) + 1, int'(we_off)), int'(re_off)) + $urandom_range(0, 3));
        wr_cyc = 6'(int'(we_off) + $urandom_range(0, 4));
        rd_cyc = 6'(int'(re_off) + $urandom_range(0, 4));
        lr     = imax(int'(rd_cyc), int'(cs_off));
        acc    = 6'($urandom_range(int'(re_on) + 1, lr));
        gap    = 6'($urandom_range(0, 3));
        x2     = 1'($urandom_range(0, 1));
        pcs = 1'($urandom_range(0, 1)); pwe = 1'($urandom_range(0, 1));
        pre = 1'($urandom_range(0, 1)); pa0 = 1'($urandom_range(0, 1));
    endtask

    // One legal access, checked clock by clock (R2..R7, R9, R10)
    task automatic run_access(input bit rd, input bit ds, input logic [DW-1:0] wd, input bit perturb);
        int g = x2 ? 2 : 1;
        int c_on = int'(cs_on), c_off = int'(cs_off);
        int w_on = int'(we_on), w_off = int'(we_off);
        int r_on = int'(re_on), r_off = int'(re_off);
        int len = imax(rd ? int'(rd_cyc) : int'(wr_cyc), int'(cs_off));
        int gp = int'(gap), a = int'(acc), accn;
        int s_act = 0, s_exp = 0;
        bit s_ok = 1, a_ok = 1, o_ok = 1, r_ok = 1, d_ok = 1, x_ok = 1;
        logic [5:0] sv_we_off = we_off, sv_cs_off = cs_off, sv_wr = wr_cyc, sv_rd = rd_cyc;
        logic sv_x2 = x2;
        valid = 1'b1; rdreq = rd; dsel = ds; wdata = wd;
        while (ready !== 1'b1) @(negedge clk);
        @(negedge clk);
        accn = cc;
        valid = 1'b0;
        if (perturb) begin
            we_off = 6'd63; cs_off = 6'd2; wr_cyc = 6'd1; rd_cyc = 6'd60; x2 = ~x2;
        end
        for (int k = 0; k <= (len + gp) * g; k++) begin
            int t = k / g;
            bit inrun = (k < len * g);
            bit ecs = inrun && t >= c_on && t < c_off;
            bit ewe = inrun && !rd && t >= w_on && t < w_off;
            bit ere = inrun && rd && t >= r_on && t < r_off;
            if (bcs !== lvl(ecs, pcs) || bwe !== lvl(ewe, pwe) || bre !== lvl(ere, pre)) begin
                if (s_ok) begin
                    s_act = {29'd0, bcs, bwe, bre};
                    s_exp = {29'd0, lvl(ecs, pcs), lvl(ewe, pwe), lvl(ere, pre)};
                end
                s_ok = 0;
            end
            if (bwe !== lvl(1'b0, pwe) && bre !== lvl(1'b0, pre)) x_ok = 0;
            if (ba0 !== (ds ^ pa0)) a_ok = 0;
            if (boe !== (inrun && !rd) || (inrun && !rd && bdout !== wd)) o_ok = 0;
            if (ready !== (k >= (len + gp) * g)) r_ok = 0;
            if (k == len * g) begin
                chk(wr_done === !rd, "R3", "wr_done at cycle end", int'(wr_done), int'(!rd));
                chk(rd_valid === rd, "R4", "rd_valid at cycle end", int'(rd_valid), int'(rd));
                if (rd)
                    chk(rd_data === hash(accn + a * g - 1), "R4", "rd_data sample",
                        int'(rd_data), int'(hash(accn + a * g - 1)));
            end else if (wr_done !== 1'b0 || rd_valid !== 1'b0) begin
                d_ok = 0;
            end
            if (k < (len + gp) * g) @(negedge clk);
        end
        if (perturb) begin
            we_off = sv_we_off; cs_off = sv_cs_off; wr_cyc = sv_wr; rd_cyc = sv_rd; x2 = sv_x2;
        end
        chk(s_ok, perturb ? "R9 R2 R7" : "R2 R7", "strobe levels {cs,we,re}", s_act, s_exp);
        chk(x_ok, "R10", "we and re overlap", 1, 0);
        chk(a_ok, "R6", "a0 level", int'(ba0), int'(ds ^ pa0));
        chk(o_ok, "R3", "bus_oe/bus_dout", int'(bdout), int'(wd));
        chk(r_ok, "R5", "ready timing", int'(ready), 1);
        chk(d_ok, "R3 R4", "end pulse outside cycle end", 1, 0);
    endtask

    // Illegal set: consumed, flagged, bus untouched (R8)
    task automatic run_illegal(input string why);
        valid = 1'b1; rdreq = 1'b0; dsel = 1'b1; wdata = 16'hBEEF;
        while (ready !== 1'b1) @(negedge clk);
        @(negedge clk);
        valid = 1'b0;
        chk(cfg_err === 1'b1, "R8", {why, " cfg_err"}, int'(cfg_err), 1);
        chk(ready === 1'b1 && bcs === !pcs && bwe === !pwe && boe === 1'b0, "R8",
            {why, " bus idle"}, int'({bcs, bwe, boe, ready}), int'({!pcs, !pwe, 1'b0, 1'b1}));
        @(negedge clk);
        chk(cfg_err === 1'b0 && bcs === !pcs && wr_done === 1'b0, "R8",
            {why, " pulse length"}, int'(cfg_err), 0);
    endtask

    task automatic set_min();
        cs_on = 4'd0; cs_off = 6'd1; we_on = 4'd0; we_off = 6'd1; re_on = 4'd0; re_off = 6'd1;
        wr_cyc = 6'd1; rd_cyc = 6'd1; acc = 6'd1; gap = 6'd0; x2 = 1'b0;
    endtask

    initial begin : watchdog
        #(20 * 150000);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5eed_1234));
        valid = 0; rdreq = 0; dsel = 0; wdata = '0;
        set_min();
        pcs = 1'b0; pwe = 1'b0; pre = 1'b1; pa0 = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ready === 1'b1 && wr_done === 1'b0 && rd_valid === 1'b0 && cfg_err === 1'b0 && boe === 1'b0,
            "R1", "handshake/pulses in reset", int'({ready, wr_done, rd_valid, cfg_err, boe}), 16);
        chk(bcs === 1'b1 && bwe === 1'b1 && bre === 1'b0 && ba0 === 1'b0, "R1",
            "idle strobe levels", int'({bcs, bwe, bre, ba0}), 4'b1100);
        rst = 1'b0;
        @(negedge clk);
        chk(ready === 1'b1 && bcs === 1'b1 && bre === 1'b0, "R1", "after release",
            int'({ready, bcs, bre}), 3'b110);

        // Shortest cycle, back to back, command then data (R2, R3, R6)
        run_access(1'b0, 1'b0, 16'h1234, 1'b0);
        run_access(1'b0, 1'b1, 16'h5678, 1'b0);
        run_access(1'b1, 1'b1, 16'h0000, 1'b0);

        // All fields at the top, doubled ticks, read sampled on the last tick (R4)
        cs_on = 4'd15; cs_off = 6'd63; we_on = 4'd15; we_off = 6'd40; re_on = 4'd15; re_off = 6'd50;
        wr_cyc = 6'd63; rd_cyc = 6'd63; acc = 6'd63; gap = 6'd3; x2 = 1'b1;
        pcs = 1'b1; pwe = 1'b1; pre = 1'b0; pa0 = 1'b1;
        run_access(1'b1, 1'b0, 16'h0, 1'b0);
        run_access(1'b0, 1'b1, 16'hA5A5, 1'b0);

        // Illegal orderings, one rule broken each (R8)
        rand_cfg(); acc = 6'(re_on);
        run_illegal("access not after RE on");
        rand_cfg(); cs_off = 6'(int'(we_off) - 1); if (int'(cs_off) <= int'(cs_on)) cs_on = 4'd0;
        run_illegal("CS off before WE off");
        rand_cfg(); we_off = 6'(we_on);
        run_illegal("WE off equals WE on");

        // Inputs rewritten mid-access (R9)
        rand_cfg();
        run_access(1'b0, 1'b1, 16'hC3C3, 1'b1);
        rand_cfg();
        run_access(1'b1, 1'b0, 16'h0, 1'b1);

        // Random legal sets and accesses
        for (int i = 0; i < 120; i++) begin
            rand_cfg();
            run_access(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                       16'($urandom_range(0, 65535)), 1'b0);
        end

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule